// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block decides, for the instruction in the execute stage of a five-stage in-order pipeline, where each operand should come from. The instruction one step ahead (between execute and memory) and the instruction two steps ahead (between memory and writeback) may hold a result that has not yet reached the register file. The unit compares the execute-stage source register numbers against their destination numbers. It produces a multiplexer select for each ALU operand. The multiplexers themselves sit outside the block.

A third select serves the store-data input of the memory stage. When a store sits in the memory stage and its data register is being written by the instruction in writeback, the writeback value is routed straight to the memory write data. The address input is never a candidate for that path.

The unit is purely combinational and has no clock or state. The register file writes early in the cycle, so a producer three or more instructions ahead is already visible through the normal register read and needs no select. There are no states and no transitions. Every output is a function of the current inputs.

Top module: `fwd_select_unit`

## Requirements
- R1: `sel_a` is 0 (take the execute/memory result) whenever `dx_rs1` matches a qualifying destination in the execute/memory stage.
- R2: When R1 does not apply, `sel_a` is 1 (take the memory/writeback result) if `dx_rs1` matches a qualifying destination in the memory/writeback stage. Otherwise it is 2 (take the register-file value).
- R3: `sel_b` follows the same rules as R1 and R2, keyed on `dx_rs2`, and is independent of `sel_a`.
- R4: A destination qualifies only when that stage's valid flag and register-write flag are both 1.
- R5: Register number 0 never qualifies, so a source of 0 always selects 2.
- R6: When both older stages qualify for the same source, the select is 0, because the younger result wins.
- R7: `sel_st` is 1 when `xm_store` is 1 and `xm_st_src` matches a qualifying memory/writeback destination. In every other case it is 2, and it is never 0.
- R8: No select ever takes the value 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dx_rs1 | input | REG_AW | First source register of the execute-stage instruction |
| dx_rs2 | input | REG_AW | Second source register of the execute-stage instruction |
| xm_valid | input | 1 | Execute/memory stage holds a real instruction |
| xm_wr | input | 1 | Execute/memory instruction writes a register |
| xm_rd | input | REG_AW | Execute/memory destination register |
| xm_store | input | 1 | Execute/memory instruction is a store |
| xm_st_src | input | REG_AW | Data register of the store in execute/memory |
| mw_valid | input | 1 | Memory/writeback stage holds a real instruction |
| mw_wr | input | 1 | Memory/writeback instruction writes a register |
| mw_rd | input | REG_AW | Memory/writeback destination register |
| sel_a | output | 2 | ALU operand A select: 0 X/M, 1 M/W, 2 register file |
| sel_b | output | 2 | ALU operand B select, same encoding |
| sel_st | output | 2 | Store-data select: 1 M/W, 2 register file |

## Verification
The block has no state, so a wrong internal decision shows up at once on a select output, in the same cycle the inputs are applied. A broken comparator makes one select stick at 2 when it should forward, or forward a stale value. A swapped priority picks 1 where 0 is expected only when both stages name the same register. For this reason the stimulus draws register numbers from a narrow range, so that double matches, register 0 and write-disabled producers occur often.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
    typedef enum logic [1:0] {
        FWD_XM = 2'd0,
        FWD_MW = 2'd1,
        FWD_RF = 2'd2
    } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              prod_valid,
    input  logic              prod_wr,
    input  logic [REG_AW-1:0] prod_rd,
    output logic              hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = prod_valid && prod_wr && (prod_rd != ZERO_REG) && (prod_rd == src);
    end

    always_comb begin
        if (!$isunknown({src, prod_valid, prod_wr, prod_rd})) begin
            assert_zero_never_hits_R5: assert (!(hit && src == ZERO_REG))
                else $error("register 0 matched");
            assert_idle_never_hits_R4: assert (!(hit && !(prod_valid && prod_wr)))
                else $error("non-writing producer matched");
        end
    end
endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
    import fwd_pkg::*;
(
    input  logic       hit_young,
    input  logic       hit_old,
    output logic [1:0] sel
);
    fwd_sel_e choice;

    always_comb begin
        if (hit_young)
            choice = FWD_XM;
        else if (hit_old)
            choice = FWD_MW;
        else
            choice = FWD_RF;
        sel = choice;
    end

    always_comb begin
        if (!$isunknown({hit_young, hit_old})) begin
            assert_young_wins_R6: assert (!(hit_young && hit_old) || sel == 2'd0)
                else $error("older result chosen over younger");
            assert_legal_code_R8: assert (sel != 2'd3)
                else $error("illegal select code");
        end
    end
endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
    import fwd_pkg::*;
#(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] dx_rs1,
    input  logic [REG_AW-1:0] dx_rs2,
    input  logic              xm_valid,
    input  logic              xm_wr,
    input  logic [REG_AW-1:0] xm_rd,
    input  logic              xm_store,
    input  logic [REG_AW-1:0] xm_st_src,
    input  logic              mw_valid,
    input  logic              mw_wr,
    input  logic [REG_AW-1:0] mw_rd,
    output logic [1:0]        sel_a,
    output logic [1:0]        sel_b,
    output logic [1:0]        sel_st
);
    localparam int N_ALU_SRC = 2;

    logic [REG_AW-1:0] alu_src [N_ALU_SRC];
    logic [1:0]        alu_sel [N_ALU_SRC];

    assign alu_src[0] = dx_rs1;
    assign alu_src[1] = dx_rs2;

    for (genvar k = 0; k < N_ALU_SRC; k++) begin : g_alu
        logic hit_xm;
        logic hit_mw;

        fwd_match #(.REG_AW(REG_AW)) u_xm (
            .src(alu_src[k]), .prod_valid(xm_valid), .prod_wr(xm_wr),
            .prod_rd(xm_rd), .hit(hit_xm)
        );
        fwd_match #(.REG_AW(REG_AW)) u_mw (
            .src(alu_src[k]), .prod_valid(mw_valid), .prod_wr(mw_wr),
            .prod_rd(mw_rd), .hit(hit_mw)
        );
        fwd_prio u_prio (
            .hit_young(hit_xm), .hit_old(hit_mw), .sel(alu_sel[k])
        );
    end

    assign sel_a = alu_sel[0];
    assign sel_b = alu_sel[1];

    // store data path: only the writeback producer can feed the memory stage
    logic st_hit;
    logic st_young_none;

    assign st_young_none = 1'b0;

    fwd_match #(.REG_AW(REG_AW)) u_st_mw (
        .src(xm_st_src), .prod_valid(mw_valid && xm_store), .prod_wr(mw_wr),
        .prod_rd(mw_rd), .hit(st_hit)
    );
    fwd_prio u_st_prio (
        .hit_young(st_young_none), .hit_old(st_hit), .sel(sel_st)
    );

    always_comb begin
        if (!$isunknown({dx_rs1, dx_rs2, xm_valid, xm_wr, xm_rd,
                         xm_store, xm_st_src, mw_valid, mw_wr, mw_rd})) begin
            assert_store_never_xm_R7: assert (sel_st != 2'd0)
                else $error("store data took execute result");
            assert_store_only_for_store_R7: assert (xm_store || sel_st == 2'd2)
                else $error("store forward without a store");
            assert_rs1_zero_rf_R5: assert (dx_rs1 != '0 || sel_a == 2'd2)
                else $error("operand A forwarded register 0");
            assert_no_producers_rf_R4: assert ((xm_valid && xm_wr) || (mw_valid && mw_wr)
                                               || (sel_a == 2'd2 && sel_b == 2'd2))
                else $error("forward without a writing producer");
        end
    end
endmodule

// File: tb/fwd_select_unit_tb_top.sv
module fwd_select_unit_tb_top;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [AW-1:0] dx_rs1 = '0, dx_rs2 = '0, xm_rd = '0, xm_st_src = '0, mw_rd = '0;
    logic xm_valid = 1'b0, xm_wr = 1'b0, xm_store = 1'b0, mw_valid = 1'b0, mw_wr = 1'b0;
    logic [1:0] sel_a, sel_b, sel_st;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    fwd_select_unit #(.REG_AW(AW)) dut_i (
        .dx_rs1(dx_rs1), .dx_rs2(dx_rs2), .xm_valid(xm_valid), .xm_wr(xm_wr),
        .xm_rd(xm_rd), .xm_store(xm_store), .xm_st_src(xm_st_src),
        .mw_valid(mw_valid), .mw_wr(mw_wr), .mw_rd(mw_rd),
        .sel_a(sel_a), .sel_b(sel_b), .sel_st(sel_st)
    );

    function automatic logic [1:0] exp_alu(logic [AW-1:0] s);
        if (xm_valid && xm_wr && xm_rd != 0 && xm_rd == s) return 2'd0;
        if (mw_valid && mw_wr && mw_rd != 0 && mw_rd == s) return 2'd1;
        return 2'd2;
    endfunction

    function automatic logic [1:0] exp_st();
        if (xm_store && mw_valid && mw_wr && mw_rd != 0 && mw_rd == xm_st_src) return 2'd1;
        return 2'd2;
    endfunction

    task automatic chk(string req, logic [1:0] act, logic [1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply(logic [AW-1:0] r1, logic [AW-1:0] r2,
                         logic xv, logic xw, logic [AW-1:0] xd, logic xs, logic [AW-1:0] xsrc,
                         logic mv, logic mwr, logic [AW-1:0] md);
        @(negedge clk);
        dx_rs1 = r1; dx_rs2 = r2; xm_valid = xv; xm_wr = xw; xm_rd = xd;
        xm_store = xs; xm_st_src = xsrc; mw_valid = mv; mw_wr = mwr; mw_rd = md;
        #1;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // idle after reset: no producers -> all register file (R4)
        apply(3, 4, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R4 idle a", sel_a, 2'd2); chk("R4 idle b", sel_b, 2'd2); chk("R7 idle st", sel_st, 2'd2);
        // R1 execute/memory match on rs1
        apply(3, 4, 1, 1, 3, 0, 0, 0, 0, 0);
        chk("R1 xm hit a", sel_a, 2'd0); chk("R3 b untouched", sel_b, 2'd2);
        // R2 memory/writeback match on rs1
        apply(3, 4, 1, 1, 9, 0, 0, 1, 1, 3);
        chk("R2 mw hit a", sel_a, 2'd1);
        // R6 both match
        apply(7, 7, 1, 1, 7, 0, 0, 1, 1, 7);
        chk("R6 prio a", sel_a, 2'd0); chk("R6 prio b", sel_b, 2'd0);
        // R3 independent selects
        apply(5, 6, 1, 1, 6, 0, 0, 1, 1, 5);
        chk("R3 a from mw", sel_a, 2'd1); chk("R3 b from xm", sel_b, 2'd0);
        // R5 register 0
        apply(0, 0, 1, 1, 0, 1, 0, 1, 1, 0);
        chk("R5 zero a", sel_a, 2'd2); chk("R5 zero b", sel_b, 2'd2); chk("R5 zero st", sel_st, 2'd2);
        // R4 write flag off / valid off
        apply(8, 8, 1, 0, 8, 0, 0, 0, 1, 8);
        chk("R4 no write a", sel_a, 2'd2); chk("R4 invalid b", sel_b, 2'd2);
        // R4 invalid xm falls through to mw
        apply(8, 2, 0, 1, 8, 0, 0, 1, 1, 8);
        chk("R4 fallthrough a", sel_a, 2'd1);
        // R7 store forward
        apply(1, 2, 1, 0, 0, 1, 12, 1, 1, 12);
        chk("R7 store fwd", sel_st, 2'd1);
        apply(1, 2, 1, 0, 0, 0, 12, 1, 1, 12);
        chk("R7 not store", sel_st, 2'd2);
        apply(1, 2, 1, 1, 12, 1, 12, 0, 1, 12);
        chk("R7 never xm", sel_st, 2'd2);
        // random, narrow register range
        for (int i = 0; i < 400; i++) begin
            apply($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom), 1'($urandom),
                  $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3),
                  1'($urandom), 1'($urandom), $urandom_range(0, 3));
            chk("R1/R2 rand a", sel_a, exp_alu(dx_rs1));
            chk("R3 rand b", sel_b, exp_alu(dx_rs2));
            chk("R7 rand st", sel_st, exp_st());
            n_checks++;
            if (sel_a == 2'd3 || sel_b == 2'd3 || sel_st == 2'd3) begin
                n_fail++;
                $display("FAIL R8: got code 3 expected 0..2");
            end
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule